// File: doc/BRIEF.md
# Multicart Program Bank Mapper

This block turns a CPU address in the upper half of the 16-bit space ($8000-$FFFF) into an address in a 32 MiB program ROM. The CPU window is cut into four 8 KiB slots, and each slot gets a 12-bit bank number. The low byte of that bank number mixes two values. A per-slot inner bank supplies the bits kept by a selectable mask. A shared middle bank fills every bit the mask removes. A 4-bit outer bank supplies the top nibble.

The CPU programs the mapper by writing to byte registers at fixed addresses in the $41xx page. Those registers cannot be read back. The lookup result is registered, so the ROM address appears on the clock edge after the CPU address. With every register at zero, the layout is the classic one: two switchable slots at the bottom and two fixed slots at the top, all inside the first 512 KiB.

Top module: `prg_bank_mapper`

## Requirements
- R1: While `rst` is high, every configuration register clears to zero. After the first edge with reset high, `rom_addr` is 0 and `rom_valid` is 0.
- R2: After each edge, `rom_addr` holds {bank[11:0], cpu_addr[12:0]} and `rom_valid` holds cpu_addr[15]. Both are taken from the values present before that edge.
- R3: The slot picked by cpu_addr[14:13]=00 takes its inner bank from the byte written at $4107. The slot picked by 01 takes it from the byte written at $4108.
- R4: Slot 10 uses inner bank $FE when bit 6 of $410B is 0, and the byte at $4109 when that bit is 1. Slot 11 always uses inner bank $FF.
- R5: When bit 6 of $4105 is 1, the slot index is cpu_addr[14:13] with its upper bit inverted. This swap applies to both the inner bank source and the outer bank source.
- R6: Bits 2:0 of $410B pick the inner mask. Values 0 through 6 give $3F shifted right by that value. Value 7 gives $FF.
- R7: The low byte of the bank is (inner AND mask) OR (middle AND NOT mask). The middle value is the byte written at $410A.
- R8: When bit 5 of $411C is 0, bank bits 11:8 equal bits 7:4 of $4100 for every slot.
- R9: When bit 5 of $411C is 1, the outer bank comes from a per-slot source. Slot 00 uses $4110[3:0]. Slot 01 uses $4110[7:4]. Slot 10 uses $4111[3:0] if $410B bit 6 is 1, and otherwise $4100[7:4]. Slot 11 uses $4100[7:4].
- R10: A write changes a register only when `wr_en` is high and `wr_addr` equals that register's address. Writes to any other address leave every output unchanged. A translation in the same cycle as a write still uses the old setting, and the new setting applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| cpu_addr | input | 16 | CPU address to translate |
| rom_addr | output | 25 | Registered ROM byte address |
| rom_valid | output | 1 | Registered cpu_addr[15] |

## Verification
A register write and an address translation can fall in the same clock cycle. The bench triggers this both on purpose and at random. In the directed part, it writes a slot's inner bank, middle byte or swap bit while reading through that same slot. In the random part, every cycle carries both a write and a lookup. The result is judged against a bench model whose state is updated only after the expected value for that edge has been computed. A correct design therefore shows the old mapping on that edge and the new mapping on the next one.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  localparam int CFG_W = 8;

  // Held configuration, one byte per register
  typedef struct packed {
    logic [CFG_W-1:0] outer_base;  // bits 7:4 shared outer bank
    logic [CFG_W-1:0] mode;        // bit 6 swaps slot halves
    logic [CFG_W-1:0] inner0;
    logic [CFG_W-1:0] inner1;
    logic [CFG_W-1:0] inner2;
    logic [CFG_W-1:0] middle;
    logic [CFG_W-1:0] size;        // bit 6 third slot enable, bits 2:0 mask select
    logic [CFG_W-1:0] outer01;
    logic [CFG_W-1:0] outer2;
    logic [CFG_W-1:0] ext;         // bit 5 per-slot outer enable
  } prg_cfg_t;

  localparam int SWAP_BIT    = 6;
  localparam int SLOT2_BIT   = 6;
  localparam int PERSLOT_BIT = 5;

  function automatic logic [CFG_W-1:0] inner_mask(input logic [2:0] sel);
    logic [CFG_W-1:0] m;
    if (sel == 3'd7) m = '1;
    else             m = 8'h3F >> sel;
    return m;
  endfunction

endpackage

// File: rtl/prg_cfg_regs.sv
module prg_cfg_regs
  import prg_map_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] A_OUTER_BASE = 16'h4100,
  parameter logic [ADDR_W-1:0] A_MODE       = 16'h4105,
  parameter logic [ADDR_W-1:0] A_INNER0     = 16'h4107,
  parameter logic [ADDR_W-1:0] A_INNER1     = 16'h4108,
  parameter logic [ADDR_W-1:0] A_INNER2     = 16'h4109,
  parameter logic [ADDR_W-1:0] A_MIDDLE     = 16'h410A,
  parameter logic [ADDR_W-1:0] A_SIZE       = 16'h410B,
  parameter logic [ADDR_W-1:0] A_OUTER01    = 16'h4110,
  parameter logic [ADDR_W-1:0] A_OUTER2     = 16'h4111,
  parameter logic [ADDR_W-1:0] A_EXT        = 16'h411C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output prg_cfg_t          cfg
);

  prg_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_OUTER_BASE: cfg_q.outer_base <= wr_data;
        A_MODE:       cfg_q.mode       <= wr_data;
        A_INNER0:     cfg_q.inner0     <= wr_data;
        A_INNER1:     cfg_q.inner1     <= wr_data;
        A_INNER2:     cfg_q.inner2     <= wr_data;
        A_MIDDLE:     cfg_q.middle     <= wr_data;
        A_SIZE:       cfg_q.size       <= wr_data;
        A_OUTER01:    cfg_q.outer01    <= wr_data;
        A_OUTER2:     cfg_q.outer2     <= wr_data;
        A_EXT:        cfg_q.ext        <= wr_data;
        default:      ;
      endcase
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/prg_slot_source.sv
module prg_slot_source
  import prg_map_pkg::*;
#(
  parameter int SLOT    = 0,
  parameter int INNER_W = 8,
  parameter int OUTER_W = 4
) (
  input  prg_cfg_t           cfg,
  output logic [INNER_W-1:0] inner,
  output logic [OUTER_W-1:0] outer
);

  logic               per_slot;
  logic               slot2_sel;
  logic [OUTER_W-1:0] shared_outer;

  assign per_slot     = cfg.ext[PERSLOT_BIT];
  assign slot2_sel    = cfg.size[SLOT2_BIT];
  assign shared_outer = cfg.outer_base[CFG_W-1 -: OUTER_W];

  generate
    if (SLOT == 0) begin : g_s0
      assign inner = cfg.inner0;
      assign outer = per_slot ? cfg.outer01[OUTER_W-1:0] : shared_outer;
    end else if (SLOT == 1) begin : g_s1
      assign inner = cfg.inner1;
      assign outer = per_slot ? cfg.outer01[CFG_W-1 -: OUTER_W] : shared_outer;
    end else if (SLOT == 2) begin : g_s2
      assign inner = slot2_sel ? cfg.inner2 : {{(INNER_W-1){1'b1}}, 1'b0};
      assign outer = (per_slot && slot2_sel) ? cfg.outer2[OUTER_W-1:0] : shared_outer;
    end else begin : g_s3
      assign inner = '1;
      assign outer = shared_outer;
    end
  endgenerate

endmodule

// File: rtl/prg_bank_compose.sv
module prg_bank_compose #(
  parameter int INNER_W = 8,
  parameter int OUTER_W = 4,
  localparam int BANK_W = INNER_W + OUTER_W
) (
  input  logic [INNER_W-1:0] inner,
  input  logic [INNER_W-1:0] middle,
  input  logic [INNER_W-1:0] mask,
  input  logic [OUTER_W-1:0] outer,
  output logic [BANK_W-1:0]  bank
);

  logic [INNER_W-1:0] low;

  always_comb begin
    low  = (inner & mask) | (middle & ~mask);
    bank = {outer, low};
  end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int OFFS_W  = 13,
  parameter int INNER_W = 8,
  parameter int OUTER_W = 4,
  localparam int BANK_W  = INNER_W + OUTER_W,
  localparam int ROM_W   = BANK_W + OFFS_W,
  localparam int SLOT_W  = ADDR_W - 1 - OFFS_W,
  localparam int NSLOT   = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ROM_W-1:0]  rom_addr,
  output logic              rom_valid
);

  prg_cfg_t           cfg;
  logic [INNER_W-1:0] mask;
  logic [BANK_W-1:0]  slot_bank [NSLOT];
  logic [SLOT_W-1:0]  slot_idx;
  logic [BANK_W-1:0]  sel_bank;

  prg_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg     (cfg)
  );

  assign mask = inner_mask(cfg.size[2:0]);

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic [INNER_W-1:0] inner_s;
      logic [OUTER_W-1:0] outer_s;
      prg_slot_source #(.SLOT(s), .INNER_W(INNER_W), .OUTER_W(OUTER_W)) u_src (
        .cfg   (cfg),
        .inner (inner_s),
        .outer (outer_s)
      );
      prg_bank_compose #(.INNER_W(INNER_W), .OUTER_W(OUTER_W)) u_cmp (
        .inner  (inner_s),
        .middle (cfg.middle),
        .mask   (mask),
        .outer  (outer_s),
        .bank   (slot_bank[s])
      );
    end
  endgenerate

  // Swap flips the upper slot-index bit
  assign slot_idx = cpu_addr[OFFS_W +: SLOT_W] ^
                    {cfg.mode[SWAP_BIT], {(SLOT_W-1){1'b0}}};
  assign sel_bank = slot_bank[slot_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr  <= '0;
      rom_valid <= 1'b0;
    end else begin
      rom_addr  <= {sel_bank, cpu_addr[OFFS_W-1:0]};
      rom_valid <= cpu_addr[ADDR_W-1];
    end
  end

endmodule

// File: rtl/prg_map_checker.sv
module prg_map_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [15:0] wr_addr,
  input logic [7:0]  wr_data,
  input logic [15:0] cpu_addr,
  input logic [24:0] rom_addr,
  input logic        rom_valid
);

  // Shadows rebuilt from the write port only
  logic       sh_ext;
  logic       sh_swap;
  logic [2:0] sh_sel;
  logic [3:0] sh_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_ext  <= 1'b0;
      sh_swap <= 1'b0;
      sh_sel  <= 3'd0;
      sh_base <= 4'd0;
    end else if (wr_en) begin
      if (wr_addr == 16'h411C) sh_ext  <= wr_data[5];
      if (wr_addr == 16'h4105) sh_swap <= wr_data[6];
      if (wr_addr == 16'h410B) sh_sel  <= wr_data[2:0];
      if (wr_addr == 16'h4100) sh_base <= wr_data[7:4];
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (rom_addr == '0 && !rom_valid));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rom_valid == $past(cpu_addr[15]));

  a_r2_offset_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rom_addr[12:0] == $past(cpu_addr[12:0]));

  a_r8_shared_outer: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sh_ext)) |-> rom_addr[24:21] == $past(sh_base));

  a_r4_last_slot_full: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_addr[14:13]) == 2'b11 && !$past(sh_swap) &&
     $past(sh_sel) == 3'd7) |-> rom_addr[20:13] == 8'hFF);

endmodule

bind prg_bank_mapper prg_map_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .cpu_addr  (cpu_addr),
  .rom_addr  (rom_addr),
  .rom_valid (rom_valid)
);

// File: tb/sim_prg_bank_mapper.sv
module sim_prg_bank_mapper;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cpu_addr = '0;
  logic [24:0] rom_addr;
  logic        rom_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  prg_bank_mapper u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_addr(cpu_addr),
    .rom_addr(rom_addr), .rom_valid(rom_valid)
  );

  // Bench model of the registers
  logic [7:0] m_base, m_mode, m_i0, m_i1, m_i2, m_mid, m_size, m_o01, m_o2, m_ext;

  task automatic model_clear();
    m_base = 0; m_mode = 0; m_i0 = 0; m_i1 = 0; m_i2 = 0;
    m_mid = 0; m_size = 0; m_o01 = 0; m_o2 = 0; m_ext = 0;
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    case (a)
      16'h4100: m_base = d;
      16'h4105: m_mode = d;
      16'h4107: m_i0 = d;
      16'h4108: m_i1 = d;
      16'h4109: m_i2 = d;
      16'h410A: m_mid = d;
      16'h410B: m_size = d;
      16'h4110: m_o01 = d;
      16'h4111: m_o2 = d;
      16'h411C: m_ext = d;
      default: ;
    endcase
  endtask

  function automatic logic [24:0] expect_addr(input logic [15:0] ca);
    logic [1:0] s;
    logic [7:0] inner, mask;
    logic [3:0] outer;
    logic       sel2, per;
    s    = ca[14:13];
    if (m_mode[6]) s[1] = ~s[1];
    sel2 = m_size[6];
    per  = m_ext[5];
    mask = (m_size[2:0] == 3'd7) ? 8'hFF : (8'h3F >> m_size[2:0]);
    case (s)
      2'd0: begin inner = m_i0; outer = per ? m_o01[3:0] : m_base[7:4]; end
      2'd1: begin inner = m_i1; outer = per ? m_o01[7:4] : m_base[7:4]; end
      2'd2: begin inner = sel2 ? m_i2 : 8'hFE;
                  outer = (per && sel2) ? m_o2[3:0] : m_base[7:4]; end
      default: begin inner = 8'hFF; outer = m_base[7:4]; end
    endcase
    return {outer, (inner & mask) | (m_mid & ~mask), ca[12:0]};
  endfunction

  task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: optional write plus a lookup, checked after the edge
  task automatic step(input string req, input logic we, input logic [15:0] wa,
                      input logic [7:0] wd, input logic [15:0] ca);
    logic [24:0] exp;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; cpu_addr = ca;
    exp = expect_addr(ca);
    @(posedge clk);
    if (we) model_write(wa, wd);
    #1;
    check(req, rom_addr, exp);
    check({req, " valid"}, {24'd0, rom_valid}, {24'd0, ca[15]});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    step("R10 write", 1'b1, a, d, 16'h8000);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    logic [15:0] regs [10];
    seed = 32'd1234;
    void'($urandom(seed));
    regs = '{16'h4100, 16'h4105, 16'h4107, 16'h4108, 16'h4109,
             16'h410A, 16'h410B, 16'h4110, 16'h4111, 16'h411C};
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset addr", rom_addr, 25'd0);
    check("R1 reset valid", {24'd0, rom_valid}, 25'd0);
    @(negedge clk); rst = 1'b0;

    // R1/R4 defaults: $E000 -> bank 03F, $C000 -> 03E
    step("R1 default E000", 0, 0, 0, 16'hE123);
    step("R4 default C000", 0, 0, 0, 16'hC456);
    step("R2 below window", 0, 0, 0, 16'h1FFF);
    wr(16'h4107, 8'h15);
    wr(16'h4108, 8'h2A);
    step("R3 slot0", 0, 0, 0, 16'h8ABC);
    step("R3 slot1", 0, 0, 0, 16'hA001);
    wr(16'h4109, 8'h33);
    step("R4 slot2 fixed", 0, 0, 0, 16'hC000);
    wr(16'h410B, 8'h40);
    step("R4 slot2 selectable", 0, 0, 0, 16'hDFFF);
    step("R4 slot3 fixed", 0, 0, 0, 16'hFFFF);
    wr(16'h4105, 8'h40);
    step("R5 swap 8000", 0, 0, 0, 16'h8000);
    step("R5 swap E000", 0, 0, 0, 16'hE000);
    wr(16'h410A, 8'hA5);
    for (int k = 0; k < 8; k++) begin
      wr(16'h410B, {5'b01000, k[2:0]});
      step("R6 mask slot0", 0, 0, 0, 16'h8010);
      step("R7 middle slot1", 0, 0, 0, 16'hA010);
    end
    wr(16'h4100, 8'h90);
    step("R8 shared outer", 0, 0, 0, 16'h9000);
    wr(16'h4110, 8'h4C);
    wr(16'h4111, 8'h07);
    wr(16'h411C, 8'h20);
    for (int k = 0; k < 4; k++) step("R9 per-slot outer", 0, 0, 0, {3'b100 | k[2:0], 13'h0AA} );
    wr(16'h4105, 8'h00);
    for (int k = 0; k < 4; k++) step("R9 per-slot outer noswap", 0, 0, 0, {1'b1, k[1:0], 13'h155});
    // R10: stray write then same-cycle write/lookup
    step("R10 stray write", 1, 16'h4106, 8'hFF, 16'h8000);
    step("R10 stray observed", 0, 0, 0, 16'h8000);
    step("R10 same-cycle old", 1, 16'h4107, 8'h3C, 16'h8000);
    step("R10 next-cycle new", 0, 0, 0, 16'h8000);

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] wa;
      logic        we;
      we = ($urandom % 3) != 0;
      wa = (($urandom % 8) == 0) ? (16'h4100 | 16'($urandom % 32)) : regs[$urandom % 10];
      step("R2 random", we, wa, 8'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule